// File: doc/BRIEF.md
# Synthesizer Control-Word Loader

This block builds the divider control word for an integer-N frequency synthesizer. The word carries a 9-bit main divide value, a 4-bit swallow value, a 6-bit reference divide value and an active-low prescaler enable. Software or a host controller can load the word in three ways. It can shift it in over a three-wire serial port. It can write it in pieces over an 8-bit bus with separate write strobes. It can drive the counter values straight from dedicated pins.

The loaded word is double-buffered. A 20-bit staging register takes every write. A 20-bit hop register copies the staging word on a transfer strobe, so a new frequency can be prepared while the old one is still in use and then switched in one step. A per-mode select input chooses which of the two registers drives the counter outputs. An 8-bit auxiliary register can be loaded through either the serial or the bus path.

Every external strobe, the serial clock and the serial data pass through two-flop synchronizers. Edges are detected in the system clock domain, and each write acts in a single system clock cycle.

Top module: `synth_prog_if`

## Requirements
- R1: When `if_direct` is 1 (direct mode), the counter outputs equal the `direct_*` inputs, and no strobe, serial clock or load-enable edge changes the staging, hop or auxiliary registers.
- R2: In serial mode (`if_direct`=0, `if_serial`=1), each synchronized rising edge of `sclk` with `sload_n` low and `aux_sel` low shifts `sdata` into bit 0 of the staging register, so the first bit sent ends at the MSB. The 20-bit frame, MSB to LSB, is prescaler enable, M[8:0], R[5:0], A[3:0]. A `sclk` edge while `sload_n` is high shifts nothing.
- R3: In serial mode with `aux_sel` high, `sclk` edges shift `sdata` into the 8-bit auxiliary register, MSB first, and leave the staging register unchanged.
- R4: The staging register is copied into the hop register on a rising edge of `sload_n` in serial mode, or on a rising edge of `hop_stb` in serial or parallel mode.
- R5: In parallel mode (`if_direct`=0, `if_serial`=0), a rising edge of `m1_stb` loads `bus_d[7]` into the prescaler enable and `bus_d[6:0]` into M[6:0].
- R6: In parallel mode, a rising edge of `m2_stb` loads `bus_d[3:2]` into R[5:4] and `bus_d[1:0]` into M[8:7].
- R7: In parallel mode, a rising edge of `a_stb` loads `bus_d[7:4]` into R[3:0] and `bus_d[3:0]` into A[3:0].
- R8: In parallel mode, a rising edge of `aux_sel` latches `bus_d` into the auxiliary register.
- R9: The counter outputs show the staging register when the active select is 1 and the hop register when it is 0. `sel_ser` is the active select in serial mode and `sel_par` in parallel mode. The other select has no effect.
- R10: Reset clears the staging, hop and auxiliary registers to zero.
- R11: Parallel strobes have no effect in serial mode. Serial clock and load-enable edges have no effect in parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_direct | input | 1 | 1 selects direct mode |
| if_serial | input | 1 | With if_direct=0: 1 serial, 0 parallel |
| sclk | input | 1 | Serial shift clock |
| sdata | input | 1 | Serial data, MSB first |
| sload_n | input | 1 | Serial load enable, shifting while low |
| aux_sel | input | 1 | Serial: route bits to auxiliary register; parallel: auxiliary write strobe |
| bus_d | input | 8 | Parallel data bus |
| m1_stb | input | 1 | Parallel write strobe for prescaler enable and M[6:0] |
| m2_stb | input | 1 | Parallel write strobe for R[5:4] and M[8:7] |
| a_stb | input | 1 | Parallel write strobe for R[3:0] and A |
| hop_stb | input | 1 | Staging to hop transfer strobe |
| sel_ser | input | 1 | Register select in serial mode (1 staging) |
| sel_par | input | 1 | Register select in parallel mode (1 staging) |
| direct_pre_en | input | 1 | Direct-mode prescaler enable |
| direct_m | input | 9 | Direct-mode M value |
| direct_r | input | 6 | Direct-mode R value |
| direct_a | input | 4 | Direct-mode A value |
| cnt_pre_en | output | 1 | Prescaler enable, active low |
| cnt_m | output | 9 | M counter value |
| cnt_r | output | 6 | R counter value |
| cnt_a | output | 4 | A counter value |
| aux_q | output | 8 | Auxiliary register contents |

## Verification
The assertions watch three things on every cycle. The hop register changes only in the cycle after a transfer. Nothing moves in direct mode or on a `sclk` edge while `sload_n` is high. A serial shift moves the staging word up by one bit with the synchronized data bit in bit 0, and an auxiliary shift leaves the staging word alone. Some behaviours only the bench scenarios can show. These are the field placement of each parallel strobe, the full serial frame order, the select muxing between the two registers and the direct pass-through. The bench also shows that the foreign strobes are ignored when the mode is switched, by reading both registers back through the select inputs.

// File: rtl/synth_prog_pkg.sv
`timescale 1ns/1ps
package synth_prog_pkg;
    localparam int M_W    = 9;
    localparam int R_W    = 6;
    localparam int A_W    = 4;
    localparam int AUX_W  = 8;
    localparam int BUS_W  = 8;
    localparam int WORD_W = 1 + M_W + R_W + A_W;

    // synchronized input indices
    localparam int IX_SCLK  = 0;
    localparam int IX_SDATA = 1;
    localparam int IX_SLOAD = 2;
    localparam int IX_AUX   = 3;
    localparam int IX_M1    = 4;
    localparam int IX_M2    = 5;
    localparam int IX_A     = 6;
    localparam int IX_HOP   = 7;
    localparam int N_SYNC   = 8;

    typedef struct packed {
        logic           pre_en;
        logic [M_W-1:0] m;
        logic [R_W-1:0] r;
        logic [A_W-1:0] a;
    } ctrl_word_t;

    typedef enum logic [1:0] {
        MODE_PAR = 2'd0,
        MODE_SER = 2'd1,
        MODE_DIR = 2'd2
    } if_mode_e;

    typedef struct packed {
        ctrl_word_t       stage;
        ctrl_word_t       hop;
        logic [AUX_W-1:0] aux;
    } prog_state_t;
endpackage

// File: rtl/sync_edge.sv
`timescale 1ns/1ps
module sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic prev
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[LEN-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign lvl  = chain_q[STAGES-1];
    assign prev = chain_q[STAGES];
endmodule

// File: rtl/prog_regs.sv
`timescale 1ns/1ps
module prog_regs
    import synth_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  if_mode_e          mode,
    input  logic [N_SYNC-1:0] lvl,
    input  logic [N_SYNC-1:0] prev,
    input  logic [BUS_W-1:0]  bus_d,
    output ctrl_word_t        stage_q,
    output ctrl_word_t        hop_q,
    output logic [AUX_W-1:0]  aux_q
);
    prog_state_t st_d, st_q;
    logic [N_SYNC-1:0] rise;
    logic ser, par, shift_any, shift_stage, shift_aux, xfer;

    always_comb begin
        rise        = lvl & ~prev;
        ser         = (mode == MODE_SER);
        par         = (mode == MODE_PAR);
        shift_any   = ser && rise[IX_SCLK] && !lvl[IX_SLOAD];
        shift_stage = shift_any && !lvl[IX_AUX];
        shift_aux   = shift_any &&  lvl[IX_AUX];
        xfer        = (ser && rise[IX_SLOAD]) || ((ser || par) && rise[IX_HOP]);

        st_d = st_q;
        if (shift_stage)
            st_d.stage = ctrl_word_t'({st_q.stage[WORD_W-2:0], lvl[IX_SDATA]});
        if (shift_aux)
            st_d.aux = {st_q.aux[AUX_W-2:0], lvl[IX_SDATA]};
        if (par && rise[IX_M1]) begin
            st_d.stage.pre_en = bus_d[7];
            st_d.stage.m[6:0] = bus_d[6:0];
        end
        if (par && rise[IX_M2]) begin
            st_d.stage.r[5:4] = bus_d[3:2];
            st_d.stage.m[8:7] = bus_d[1:0];
        end
        if (par && rise[IX_A]) begin
            st_d.stage.r[3:0] = bus_d[7:4];
            st_d.stage.a      = bus_d[3:0];
        end
        if (par && rise[IX_AUX])
            st_d.aux = bus_d;
        if (xfer)
            st_d.hop = st_q.stage;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stage_q = st_q.stage;
    assign hop_q   = st_q.hop;
    assign aux_q   = st_q.aux;

    AST_HOP_ONLY_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(hop_q)); // R4
    AST_DIRECT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DIR) |=> ($stable(stage_q) && $stable(hop_q) && $stable(aux_q))); // R1
    AST_SHIFT_INTO_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stage |=> (stage_q[0] == $past(lvl[IX_SDATA])) &&
                        (stage_q[WORD_W-1:1] == $past(stage_q[WORD_W-2:0]))); // R2
    AST_AUX_SHIFT_KEEPS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_aux |=> $stable(stage_q)); // R3
    AST_NO_SHIFT_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ser && rise[IX_SCLK] && lvl[IX_SLOAD] && !rise[IX_SLOAD] && !rise[IX_HOP])
            |=> ($stable(stage_q) && $stable(aux_q) && $stable(hop_q))); // R2
endmodule

// File: rtl/out_select.sv
`timescale 1ns/1ps
module out_select
    import synth_prog_pkg::*;
(
    input  if_mode_e   mode,
    input  logic       sel_ser,
    input  logic       sel_par,
    input  ctrl_word_t stage_q,
    input  ctrl_word_t hop_q,
    input  ctrl_word_t direct_w,
    output ctrl_word_t out_w
);
    logic sel;

    always_comb begin
        sel = (mode == MODE_SER) ? sel_ser : sel_par;
        if (mode == MODE_DIR) out_w = direct_w;
        else if (sel)         out_w = stage_q;
        else                  out_w = hop_q;
    end
endmodule

// File: rtl/synth_prog_if.sv
`timescale 1ns/1ps
module synth_prog_if
    import synth_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             if_direct,
    input  logic             if_serial,
    input  logic             sclk,
    input  logic             sdata,
    input  logic             sload_n,
    input  logic             aux_sel,
    input  logic [BUS_W-1:0] bus_d,
    input  logic             m1_stb,
    input  logic             m2_stb,
    input  logic             a_stb,
    input  logic             hop_stb,
    input  logic             sel_ser,
    input  logic             sel_par,
    input  logic             direct_pre_en,
    input  logic [M_W-1:0]   direct_m,
    input  logic [R_W-1:0]   direct_r,
    input  logic [A_W-1:0]   direct_a,
    output logic             cnt_pre_en,
    output logic [M_W-1:0]   cnt_m,
    output logic [R_W-1:0]   cnt_r,
    output logic [A_W-1:0]   cnt_a,
    output logic [AUX_W-1:0] aux_q
);
    logic [N_SYNC-1:0] raw, lvl, prev;
    if_mode_e   mode;
    ctrl_word_t stage_q, hop_q, direct_w, out_w;

    always_comb begin
        raw           = '0;
        raw[IX_SCLK]  = sclk;
        raw[IX_SDATA] = sdata;
        raw[IX_SLOAD] = sload_n;
        raw[IX_AUX]   = aux_sel;
        raw[IX_M1]    = m1_stb;
        raw[IX_M2]    = m2_stb;
        raw[IX_A]     = a_stb;
        raw[IX_HOP]   = hop_stb;
        if (if_direct)      mode = MODE_DIR;
        else if (if_serial) mode = MODE_SER;
        else                mode = MODE_PAR;
        direct_w = '{pre_en: direct_pre_en, m: direct_m, r: direct_r, a: direct_a};
    end

    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[g]),
            .lvl  (lvl[g]),
            .prev (prev[g])
        );
    end

    prog_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .lvl    (lvl),
        .prev   (prev),
        .bus_d  (bus_d),
        .stage_q(stage_q),
        .hop_q  (hop_q),
        .aux_q  (aux_q)
    );

    out_select u_sel (
        .mode    (mode),
        .sel_ser (sel_ser),
        .sel_par (sel_par),
        .stage_q (stage_q),
        .hop_q   (hop_q),
        .direct_w(direct_w),
        .out_w   (out_w)
    );

    assign cnt_pre_en = out_w.pre_en;
    assign cnt_m      = out_w.m;
    assign cnt_r      = out_w.r;
    assign cnt_a      = out_w.a;
endmodule

// File: tb/synth_prog_if_test.sv
`timescale 1ns/1ps
module synth_prog_if_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic if_direct = 0, if_serial = 1, sclk = 0, sdata = 0, sload_n = 1, aux_sel = 0;
    logic [7:0] bus_d = 0;
    logic m1_stb = 0, m2_stb = 0, a_stb = 0, hop_stb = 0, sel_ser = 1, sel_par = 1;
    logic direct_pre_en = 0;
    logic [8:0] direct_m = 0;
    logic [5:0] direct_r = 0;
    logic [3:0] direct_a = 0;
    logic cnt_pre_en;
    logic [8:0] cnt_m;
    logic [5:0] cnt_r;
    logic [3:0] cnt_a;
    logic [7:0] aux_q;

    int n_run = 0, n_fail = 0;
    logic [19:0] exp_stage = 0, exp_hop = 0;
    logic [7:0]  exp_aux = 0;

    always #2 clk = ~clk;

    synth_prog_if uut (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] word();
        return {12'd0, cnt_pre_en, cnt_m, cnt_r, cnt_a};
    endfunction

    // read staging (s=1) or hop (s=0) through the active select
    task automatic read_reg(input logic s, output logic [31:0] w);
        sel_ser = s; sel_par = s; #1;
        w = word();
    endtask

    task automatic pulse(ref logic stb);
        stb = 1; settle();
        stb = 0; settle();
    endtask

    task automatic serial_send(input logic [19:0] v, input int nbits);
        sload_n = 0; settle();
        for (int i = nbits - 1; i >= 0; i--) begin
            sdata = v[i]; settle();
            sclk = 1;     settle();
            sclk = 0;     settle();
        end
        sload_n = 1; settle();
    endtask

    task automatic t_reset();
        logic [31:0] w;
        read_reg(1, w); chk("R10 staging after reset", w, 0);
        read_reg(0, w); chk("R10 hop after reset", w, 0);
        chk("R10 aux after reset", {24'd0, aux_q}, 0);
    endtask

    task automatic t_serial();
        logic [31:0] w;
        aux_sel = 0;
        serial_send(20'hB53C9, 20);
        exp_stage = 20'hB53C9; exp_hop = exp_stage;
        read_reg(1, w); chk("R2 serial frame into staging", w, {12'd0, exp_stage});
        chk("R2 M field of frame", {23'd0, cnt_m}, {23'd0, exp_stage[18:10]});
        read_reg(0, w); chk("R4 load-enable rise copies to hop", w, {12'd0, exp_hop});
        // sclk edges while load enable high: no shift
        sdata = 1; sclk = 1; settle(); sclk = 0; settle();
        read_reg(1, w); chk("R2 no shift while load enable high", w, {12'd0, exp_stage});
    endtask

    task automatic t_serial_aux();
        logic [31:0] w;
        aux_sel = 1; settle();
        serial_send(20'h0006D, 8);
        aux_sel = 0; settle();
        exp_aux = 8'h6D; exp_hop = exp_stage;
        chk("R3 aux serial load", {24'd0, aux_q}, {24'd0, exp_aux});
        read_reg(1, w); chk("R3 staging untouched by aux shift", w, {12'd0, exp_stage});
    endtask

    task automatic t_parallel();
        logic [31:0] w;
        if_serial = 0; settle();
        bus_d = 8'h9A; pulse(m1_stb);
        exp_stage[19] = 1'b1; exp_stage[16:10] = 7'h1A;
        read_reg(1, w); chk("R5 M1 strobe fields", w, {12'd0, exp_stage});
        bus_d = 8'h0E; pulse(m2_stb);
        exp_stage[9:8] = 2'b11; exp_stage[18:17] = 2'b10;
        read_reg(1, w); chk("R6 M2 strobe fields", w, {12'd0, exp_stage});
        bus_d = 8'h7C; pulse(a_stb);
        exp_stage[7:4] = 4'h7; exp_stage[3:0] = 4'hC;
        read_reg(1, w); chk("R7 A strobe fields", w, {12'd0, exp_stage});
        // R9: hop still old; serial select ignored in parallel mode
        sel_par = 0; sel_ser = 1; #1;
        chk("R9 parallel select 0 shows hop", word(), {12'd0, exp_hop});
        pulse(hop_stb);
        exp_hop = exp_stage;
        read_reg(0, w); chk("R4 hop strobe copies staging", w, {12'd0, exp_hop});
        bus_d = 8'h3F; pulse(aux_sel);
        exp_aux = 8'h3F;
        chk("R8 aux strobe latches bus", {24'd0, aux_q}, {24'd0, exp_aux});
    endtask

    task automatic t_ignore();
        logic [31:0] w;
        // parallel mode: serial activity ignored
        sload_n = 0; settle();
        sdata = 0;
        for (int i = 0; i < 3; i++) begin
            sclk = 1; settle(); sclk = 0; settle();
        end
        bus_d = 8'h55; pulse(m1_stb);
        exp_stage[19] = 1'b0; exp_stage[16:10] = 7'h55;
        sload_n = 1; settle();
        read_reg(1, w); chk("R11 sclk ignored in parallel", w, {12'd0, exp_stage});
        read_reg(0, w); chk("R11 load-enable rise ignored in parallel", w, {12'd0, exp_hop});
        // serial mode: parallel strobes ignored
        if_serial = 1; settle();
        bus_d = 8'hFF;
        pulse(m1_stb); pulse(m2_stb); pulse(a_stb);
        read_reg(1, w); chk("R11 parallel strobes ignored in serial", w, {12'd0, exp_stage});
        // serial mode uses sel_ser; sel_par ignored
        sel_ser = 0; sel_par = 1; #1;
        chk("R9 serial select 0 shows hop", word(), {12'd0, exp_hop});
    endtask

    task automatic t_direct();
        logic [31:0] w;
        if_direct = 1;
        direct_pre_en = 1; direct_m = 9'h1C3; direct_r = 6'h2A; direct_a = 4'h5;
        #1;
        chk("R1 direct pass-through", word(), {12'd0, 1'b1, 9'h1C3, 6'h2A, 4'h5});
        direct_m = 9'h00F; #1;
        chk("R1 direct follows pins", word(), {12'd0, 1'b1, 9'h00F, 6'h2A, 4'h5});
        pulse(hop_stb);
        sload_n = 0; settle(); sdata = 1; sclk = 1; settle(); sclk = 0; settle();
        sload_n = 1; settle();
        if_direct = 0; settle();
        read_reg(1, w); chk("R1 staging held in direct mode", w, {12'd0, exp_stage});
        read_reg(0, w); chk("R1 hop held in direct mode", w, {12'd0, exp_hop});
    endtask

    initial begin
        #400000;
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        settle();
        t_reset();
        t_serial();
        t_serial_aux();
        t_parallel();
        t_ignore();
        t_direct();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule